// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and presents them to a processor on two lines: a normal interrupt request and a fast interrupt request. Each line has its own enable mask. Software can only change a mask through two word addresses. One address sets the mask bits that are written as 1. The other clears the mask bits that are written as 1. No address overwrites a mask directly. Each output line is the OR of the pending bits that its own mask lets through. The block does no prioritisation, vectoring or edge capture.

Source 0 is also driven by a software flag. This lets firmware raise an interrupt to itself, or to the other output line, without any hardware source. Software can read the raw pending vector and the masked status of each line on a simple word-indexed register bus. Any access to an index with no defined meaning gives a one-cycle error strobe.

Top module: `dual_intc`

## Requirements
- R1: After reset, both enable masks and the software flag are zero, both outputs are low, the read data is zero and the error strobe is low.
- R2: The pending vector follows the source inputs bit for bit. Bit 0 is also high while the software flag is set. Reads of index 1 and index 9 both return this vector.
- R3: `irq_out` is high when (pending AND IRQ mask) is non-zero, and `fiq_out` is high when (pending AND FIQ mask) is non-zero. Both outputs are registered and change at the first rising edge after an input change or a register write. The two masks act independently.
- R4: A write to index 2 ORs the write data into the IRQ mask. A write to index 3 clears the IRQ mask bits whose data bits are 1. A read of index 2 returns the IRQ mask.
- R5: A write to index 10 ORs the write data into the FIQ mask. A write to index 11 clears the FIQ mask bits whose data bits are 1. A read of index 10 returns the FIQ mask.
- R6: A write to index 4 with data bit 0 set raises the software flag. A write to index 5 with data bit 0 set lowers it. These writes do nothing when data bit 0 is 0. A read of index 4 returns the flag in bit 0, with all other bits 0.
- R7: A read of index 0 returns pending AND IRQ mask. A read of index 8 returns pending AND FIQ mask.
- R8: Writes to indices 0, 1, 8 and 9 change no state and raise no error.
- R9: Reads of the write-only indices 3, 5 and 11 return zero and raise no error.
- R10: An access to index 6, index 7 or any index of 12 or above changes no state. If it is a read, it returns zero. Either way it drives `bus_err` high for exactly the cycle after the access.
- R11: Read data is registered. It appears after the edge that accepts the read and holds through idle cycles and writes until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | NSRC (32) | Level-sensitive interrupt sources |
| bus_req | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_idx | input | AW (6) | Word index of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data |
| bus_err | output | 1 | One-cycle strobe after an access to an undefined index |
| irq_out | output | 1 | Normal interrupt request, registered |
| fiq_out | output | 1 | Fast interrupt request, registered |

## Verification
The hardest case to reach is source 0 when two drivers share it. The software flag and hardware input 0 are ORed, so a bench that drives only one of them cannot tell the OR apart from either driver on its own. The stimulus holds hardware input 0 low while the flag is raised and lowered. It also tries writes with data bit 0 at 0, which must not move the flag. Throughout, it watches both output lines with only one of the two masks enabling bit 0. A separate sequence checks that the outputs do not change before the edge: the bench changes a source between edges, samples the old output value first, and then samples the new value after one rising edge.

// File: rtl/dual_intc_pkg.sv
package dual_intc_pkg;

   // Number of output channels: channel 0 drives irq_out, channel 1 drives fiq_out.
   localparam int NCH       = 2;
   // The register group of each channel starts CH_STRIDE words after the previous one.
   localparam int CH_STRIDE = 8;

   // Offsets inside a channel group.
   localparam int OFS_STAT   = 0;
   localparam int OFS_RAW    = 1;
   localparam int OFS_EN_SET = 2;
   localparam int OFS_EN_CLR = 3;

   // Software flag controls. These exist only in the first group.
   localparam int IDX_SOFT_SET = 4;
   localparam int IDX_SOFT_CLR = 5;

   // Highest index that carries a meaning.
   localparam int IDX_TOP = (NCH - 1) * CH_STRIDE + OFS_EN_CLR;

   typedef enum logic [2:0] {
      RD_ZERO,
      RD_STAT,
      RD_RAW,
      RD_MASK,
      RD_SOFT
   } rd_sel_e;

endpackage

// File: rtl/dual_intc_decode.sv
module dual_intc_decode
   import dual_intc_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic           req,
   input  logic           we,
   input  logic [AW-1:0]  idx,
   output logic [NCH-1:0] en_set,
   output logic [NCH-1:0] en_clr,
   output logic           soft_set,
   output logic           soft_clr,
   output rd_sel_e        rd_sel,
   output logic           rd_ch,
   output logic           undef_acc
);

   logic [NCH-1:0] hit_stat;
   logic [NCH-1:0] hit_raw;
   logic [NCH-1:0] hit_set;
   logic [NCH-1:0] hit_clr;
   logic           hit_sset;
   logic           hit_sclr;
   logic           known;
   logic           wr;

   // One compare set per channel group.
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int BASE = c * CH_STRIDE;
      assign hit_stat[c] = (idx == AW'(BASE + OFS_STAT));
      assign hit_raw[c]  = (idx == AW'(BASE + OFS_RAW));
      assign hit_set[c]  = (idx == AW'(BASE + OFS_EN_SET));
      assign hit_clr[c]  = (idx == AW'(BASE + OFS_EN_CLR));
   end

   assign hit_sset = (idx == AW'(IDX_SOFT_SET));
   assign hit_sclr = (idx == AW'(IDX_SOFT_CLR));

   assign known = |{hit_stat, hit_raw, hit_set, hit_clr, hit_sset, hit_sclr};
   assign wr    = req & we;

   assign en_set    = {NCH{wr}} & hit_set;
   assign en_clr    = {NCH{wr}} & hit_clr;
   assign soft_set  = wr & hit_sset;
   assign soft_clr  = wr & hit_sclr;
   assign undef_acc = req & ~known;

   // Read source selection. Write-only and undefined indices fall through to zero.
   always_comb begin
      rd_sel = RD_ZERO;
      rd_ch  = 1'b0;
      for (int c = 0; c < NCH; c++) begin
         if (hit_stat[c]) begin
            rd_sel = RD_STAT;
            rd_ch  = 1'(c);
         end
         if (hit_raw[c]) begin
            rd_sel = RD_RAW;
            rd_ch  = 1'(c);
         end
         if (hit_set[c]) begin
            rd_sel = RD_MASK;
            rd_ch  = 1'(c);
         end
      end
      if (hit_sset) rd_sel = RD_SOFT;
   end

endmodule

// File: rtl/dual_intc_mask.sv
module dual_intc_mask #(
   parameter int NSRC = 32,
   parameter int DW   = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            set_stb,
   input  logic            clr_stb,
   input  logic [DW-1:0]   wdata,
   output logic [NSRC-1:0] mask_q,
   output logic [NSRC-1:0] mask_nxt
);

   logic [NSRC-1:0] wbits;

   assign wbits = wdata[NSRC-1:0];

   // Set and clear come from different indices, so at most one strobe is high.
   always_comb begin
      mask_nxt = mask_q;
      if (set_stb) mask_nxt = mask_q | wbits;
      if (clr_stb) mask_nxt = mask_q & ~wbits;
   end

   always_ff @(posedge clk) begin
      if (rst) mask_q <= '0;
      else     mask_q <= mask_nxt;
   end

endmodule

// File: rtl/dual_intc_pending.sv
module dual_intc_pending #(
   parameter int NSRC        = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] src_in,
   input  logic            soft_set,
   input  logic            soft_clr,
   input  logic            wd0,
   output logic            soft_q,
   output logic [NSRC-1:0] pend,
   output logic [NSRC-1:0] pend_nxt
);

   logic [NSRC-1:0] src_s;
   logic            soft_nxt;

   // Variant: sources used directly, or passed through a resynchroniser chain.
   if (SYNC_STAGES == 0) begin : g_direct
      assign src_s = src_in;
   end else begin : g_sync
      logic [NSRC-1:0] stg [SYNC_STAGES];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= src_in;
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign src_s = stg[SYNC_STAGES-1];
   end

   always_comb begin
      soft_nxt = soft_q;
      if (soft_set && wd0) soft_nxt = 1'b1;
      if (soft_clr && wd0) soft_nxt = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) soft_q <= 1'b0;
      else     soft_q <= soft_nxt;
   end

   assign pend     = src_s | NSRC'(soft_q);
   assign pend_nxt = src_s | NSRC'(soft_nxt);

endmodule

// File: rtl/dual_intc.sv
module dual_intc
   import dual_intc_pkg::*;
#(
   parameter int NSRC        = 32,
   parameter int DW          = 32,
   parameter int AW          = 6,
   parameter int SYNC_STAGES = 0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] src_in,
   input  logic            bus_req,
   input  logic            bus_we,
   input  logic [AW-1:0]   bus_idx,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   output logic            bus_err,
   output logic            irq_out,
   output logic            fiq_out
);

   localparam int IDX_SPAN = 1 << AW;

   // Elaboration checks on the parameters.
   if (NSRC < 1 || NSRC > DW) begin : g_bad_nsrc
      $error("dual_intc: NSRC must be in 1..DW");
   end
   if (IDX_SPAN <= IDX_TOP) begin : g_bad_aw
      $error("dual_intc: AW too narrow for the register indices");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("dual_intc: SYNC_STAGES must be in 0..3");
   end

   logic [NCH-1:0]  en_set;
   logic [NCH-1:0]  en_clr;
   logic            soft_set;
   logic            soft_clr;
   rd_sel_e         rd_sel;
   logic            rd_ch;
   logic            undef_acc;
   logic            soft_q;
   logic [NSRC-1:0] pend;
   logic [NSRC-1:0] pend_nxt;
   logic [NSRC-1:0] mask_q_a   [NCH];
   logic [NSRC-1:0] mask_nxt_a [NCH];
   logic [NCH-1:0]  out_q;
   logic [DW-1:0]   rd_val;
   logic [DW-1:0]   rdata_q;
   logic            err_q;
   logic [NSRC-1:0] irq_mask_q;
   logic [NSRC-1:0] fiq_mask_q;

   dual_intc_decode #(.AW(AW)) u_dec (
      .req       (bus_req),
      .we        (bus_we),
      .idx       (bus_idx),
      .en_set    (en_set),
      .en_clr    (en_clr),
      .soft_set  (soft_set),
      .soft_clr  (soft_clr),
      .rd_sel    (rd_sel),
      .rd_ch     (rd_ch),
      .undef_acc (undef_acc)
   );

   dual_intc_pending #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_pend (
      .clk      (clk),
      .rst      (rst),
      .src_in   (src_in),
      .soft_set (soft_set),
      .soft_clr (soft_clr),
      .wd0      (bus_wdata[0]),
      .soft_q   (soft_q),
      .pend     (pend),
      .pend_nxt (pend_nxt)
   );

   // One mask and one registered output per channel.
   for (genvar c = 0; c < NCH; c++) begin : g_chan
      dual_intc_mask #(.NSRC(NSRC), .DW(DW)) u_mask (
         .clk      (clk),
         .rst      (rst),
         .set_stb  (en_set[c]),
         .clr_stb  (en_clr[c]),
         .wdata    (bus_wdata),
         .mask_q   (mask_q_a[c]),
         .mask_nxt (mask_nxt_a[c])
      );

      always_ff @(posedge clk) begin
         if (rst) out_q[c] <= 1'b0;
         else     out_q[c] <= |(pend_nxt & mask_nxt_a[c]);
      end
   end

   assign irq_mask_q = mask_q_a[0];
   assign fiq_mask_q = mask_q_a[1];

   always_comb begin
      case (rd_sel)
         RD_STAT: rd_val = DW'(pend & mask_q_a[rd_ch]);
         RD_RAW:  rd_val = DW'(pend);
         RD_MASK: rd_val = DW'(mask_q_a[rd_ch]);
         RD_SOFT: rd_val = DW'(soft_q);
         default: rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata_q <= '0;
         err_q   <= 1'b0;
      end else begin
         if (bus_req && !bus_we) rdata_q <= rd_val;
         err_q <= undef_acc;
      end
   end

   assign bus_rdata = rdata_q;
   assign bus_err   = err_q;
   assign irq_out   = out_q[0];
   assign fiq_out   = out_q[1];

endmodule

// File: rtl/dual_intc_chk.sv
module dual_intc_chk #(
   parameter int NSRC        = 32,
   parameter int DW          = 32,
   parameter int AW          = 6,
   parameter int SYNC_STAGES = 0
) (
   input logic            clk,
   input logic            rst,
   input logic [NSRC-1:0] src_in,
   input logic            bus_req,
   input logic            bus_we,
   input logic [AW-1:0]   bus_idx,
   input logic [DW-1:0]   bus_wdata,
   input logic            bus_err,
   input logic            irq_out,
   input logic            fiq_out,
   input logic [NSRC-1:0] irq_mask,
   input logic [NSRC-1:0] fiq_mask,
   input logic            soft_q
);

   logic            undef_c;
   logic            wr_c;
   logic [NSRC-1:0] wbits;
   logic [NSRC-1:0] pend_c;

   assign undef_c = (bus_idx == AW'(6)) || (bus_idx == AW'(7)) || (bus_idx >= AW'(12));
   assign wr_c    = bus_req && bus_we;
   assign wbits   = bus_wdata[NSRC-1:0];
   assign pend_c  = src_in | NSRC'(soft_q);

   // R10: the error strobe follows an undefined access by exactly one cycle
   assert_err_strobe_R10: assert property (@(posedge clk) disable iff (rst)
      (bus_req && undef_c) |=> bus_err);
   assert_err_quiet_R10: assert property (@(posedge clk) disable iff (rst)
      !(bus_req && undef_c) |=> !bus_err);

   // R4: set and clear addresses of the IRQ mask
   assert_irq_set_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_c && bus_idx == AW'(2)) |=> ((irq_mask & $past(wbits)) == $past(wbits)));
   assert_irq_clr_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_c && bus_idx == AW'(3)) |=> ((irq_mask & $past(wbits)) == '0));

   // R5: set and clear addresses of the FIQ mask
   assert_fiq_set_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_c && bus_idx == AW'(10)) |=> ((fiq_mask & $past(wbits)) == $past(wbits)));
   assert_fiq_clr_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_c && bus_idx == AW'(11)) |=> ((fiq_mask & $past(wbits)) == '0));

   // R6: software flag set and clear
   assert_soft_set_R6: assert property (@(posedge clk) disable iff (rst)
      (wr_c && bus_idx == AW'(4) && bus_wdata[0]) |=> soft_q);
   assert_soft_clr_R6: assert property (@(posedge clk) disable iff (rst)
      (wr_c && bus_idx == AW'(5) && bus_wdata[0]) |=> !soft_q);

   // R8: writes to status indices leave all state alone
   assert_ro_write_R8: assert property (@(posedge clk) disable iff (rst)
      (wr_c && (bus_idx == AW'(0) || bus_idx == AW'(1) || bus_idx == AW'(8) || bus_idx == AW'(9)))
      |=> ($stable(irq_mask) && $stable(fiq_mask) && $stable(soft_q)));

   // R3: with no write, each output follows the masked pending vector one edge later
   if (SYNC_STAGES == 0) begin : g_out_chk
      assert_irq_follow_R3: assert property (@(posedge clk) disable iff (rst)
         !wr_c |=> (irq_out == ($past(pend_c & irq_mask) != '0)));
      assert_fiq_follow_R3: assert property (@(posedge clk) disable iff (rst)
         !wr_c |=> (fiq_out == ($past(pend_c & fiq_mask) != '0)));
   end

endmodule

bind dual_intc dual_intc_chk #(
   .NSRC(NSRC), .DW(DW), .AW(AW), .SYNC_STAGES(SYNC_STAGES)
) i_chk (
   .clk       (clk),
   .rst       (rst),
   .src_in    (src_in),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_idx   (bus_idx),
   .bus_wdata (bus_wdata),
   .bus_err   (bus_err),
   .irq_out   (irq_out),
   .fiq_out   (fiq_out),
   .irq_mask  (irq_mask_q),
   .fiq_mask  (fiq_mask_q),
   .soft_q    (soft_q)
);

// File: tb/test_dual_intc.sv
module test_dual_intc;

   localparam int NSRC = 32;
   localparam int DW   = 32;
   localparam int AW   = 6;

   logic            clk = 1'b0;
   logic            rst;
   logic [NSRC-1:0] src_in;
   logic            bus_req;
   logic            bus_we;
   logic [AW-1:0]   bus_idx;
   logic [DW-1:0]   bus_wdata;
   logic [DW-1:0]   bus_rdata;
   logic            bus_err;
   logic            irq_out;
   logic            fiq_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   dual_intc #(.NSRC(NSRC), .DW(DW), .AW(AW)) i_dual_intc (
      .clk       (clk),
      .rst       (rst),
      .src_in    (src_in),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_idx   (bus_idx),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_err   (bus_err),
      .irq_out   (irq_out),
      .fiq_out   (fiq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // Drive at a falling edge; the access is taken at the next rising edge.
   // The task returns at the falling edge after that, with the error strobe captured.
   task automatic wr(input int idx, input logic [31:0] d, output logic err);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_idx = AW'(idx); bus_wdata = d;
      @(negedge clk);
      err = bus_err;
      bus_req = 1'b0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input int idx, output logic [31:0] d, output logic err);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_idx = AW'(idx);
      @(negedge clk);
      d = bus_rdata; err = bus_err;
      bus_req = 1'b0;
   endtask

   task automatic set_src(input logic [31:0] v);
      @(negedge clk);
      src_in = v;
      @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d; logic e;
      chk("R1 irq_out", 32'(irq_out), 0);
      chk("R1 fiq_out", 32'(fiq_out), 0);
      chk("R1 rdata", bus_rdata, 0);
      chk("R1 err", 32'(bus_err), 0);
      rd(2, d, e);  chk("R1 irq mask", d, 0);
      rd(10, d, e); chk("R1 fiq mask", d, 0);
      rd(4, d, e);  chk("R1 soft flag", d, 0);
   endtask

   task automatic t_raw;
      logic [31:0] d; logic e;
      set_src(32'hA5A5_0F0E);
      rd(1, d, e); chk("R2 raw idx1", d, 32'hA5A5_0F0E);
      rd(9, d, e); chk("R2 raw idx9", d, 32'hA5A5_0F0E);
      chk("R3 no mask irq low", 32'(irq_out), 0);
      set_src(32'h0);
   endtask

   task automatic t_irq_mask;
      logic [31:0] d; logic e;
      wr(2, 32'h0000_00F0, e);
      rd(2, d, e); chk("R4 irq mask set", d, 32'h0000_00F0);
      wr(2, 32'h0000_0300, e);
      rd(2, d, e); chk("R4 irq mask or", d, 32'h0000_03F0);
      // output timing: old value before the edge, new value after it
      @(negedge clk);
      src_in = 32'h0000_0010;
      #1 chk("R3 irq before edge", 32'(irq_out), 0);
      @(negedge clk);
      chk("R3 irq after edge", 32'(irq_out), 1);
      chk("R3 fiq independent", 32'(fiq_out), 0);
      rd(0, d, e); chk("R7 irq status", d, 32'h0000_0010);
      rd(8, d, e); chk("R7 fiq status empty", d, 0);
      wr(3, 32'h0000_0110, e);
      chk("R3 irq drops on clear", 32'(irq_out), 0);
      rd(2, d, e); chk("R4 irq mask clr", d, 32'h0000_02E0);
      wr(3, 32'hFFFF_FFFF, e);
      set_src(32'h0);
   endtask

   task automatic t_fiq_mask;
      logic [31:0] d; logic e;
      wr(10, 32'h8000_0001, e);
      rd(10, d, e); chk("R5 fiq mask set", d, 32'h8000_0001);
      chk("R5 fiq low no src", 32'(fiq_out), 0);
      set_src(32'h8000_4000);
      chk("R3 fiq high", 32'(fiq_out), 1);
      chk("R3 irq stays low", 32'(irq_out), 0);
      rd(8, d, e); chk("R7 fiq status", d, 32'h8000_0000);
      wr(11, 32'h8000_0000, e);
      chk("R5 fiq low after clr", 32'(fiq_out), 0);
      rd(10, d, e); chk("R5 fiq mask clr", d, 32'h0000_0001);
      set_src(32'h0);
   endtask

   task automatic t_soft;
      logic [31:0] d; logic e;
      // FIQ mask bit 0 is still set from t_fiq_mask; IRQ mask is empty
      wr(4, 32'hFFFF_FFFE, e);
      rd(4, d, e); chk("R6 set ignored bit0=0", d, 0);
      chk("R6 fiq low", 32'(fiq_out), 0);
      wr(4, 32'h0000_0001, e);
      chk("R6 fiq from soft", 32'(fiq_out), 1);
      chk("R6 irq unmasked low", 32'(irq_out), 0);
      rd(4, d, e); chk("R6 soft read", d, 32'h1);
      rd(1, d, e); chk("R2 raw with soft", d, 32'h1);
      wr(5, 32'h0000_0002, e);
      rd(4, d, e); chk("R6 clr ignored bit0=0", d, 32'h1);
      wr(5, 32'h0000_0001, e);
      chk("R6 fiq low after clr", 32'(fiq_out), 0);
      rd(1, d, e); chk("R2 raw soft gone", d, 0);
      // hardware bit 0 alone still counts
      set_src(32'h1);
      chk("R2 hw bit0 fiq", 32'(fiq_out), 1);
      set_src(32'h0);
      wr(11, 32'hFFFF_FFFF, e);
   endtask

   task automatic t_ro_writes;
      logic [31:0] d; logic e;
      wr(2, 32'h0000_5555, e);
      foreach (ro_list[i]) begin
         wr(ro_list[i], 32'hFFFF_FFFF, e);
         chk("R8 no err", 32'(e), 0);
      end
      rd(2, d, e);  chk("R8 irq mask kept", d, 32'h0000_5555);
      rd(10, d, e); chk("R8 fiq mask kept", d, 0);
      rd(4, d, e);  chk("R8 soft kept", d, 0);
   endtask

   int ro_list [4] = '{0, 1, 8, 9};
   int wo_list [3] = '{3, 5, 11};

   task automatic t_wo_reads;
      logic [31:0] d; logic e;
      foreach (wo_list[i]) begin
         rd(wo_list[i], d, e);
         chk("R9 wo read zero", d, 0);
         chk("R9 wo read no err", 32'(e), 0);
      end
   endtask

   task automatic t_undef;
      logic [31:0] d; logic e;
      wr(6, 32'hFFFF_FFFF, e); chk("R10 err on write 6", 32'(e), 1);
      @(negedge clk);          chk("R10 err one cycle", 32'(bus_err), 0);
      wr(12, 32'hFFFF_FFFF, e); chk("R10 err on write 12", 32'(e), 1);
      rd(2, d, e);  chk("R10 irq mask kept", d, 32'h0000_5555);
      rd(7, d, e);  chk("R10 read 7 zero", d, 0);  chk("R10 read 7 err", 32'(e), 1);
      rd(63, d, e); chk("R10 read 63 zero", d, 0); chk("R10 read 63 err", 32'(e), 1);
      rd(10, d, e); chk("R10 fiq mask kept", d, 0);
   endtask

   task automatic t_hold;
      logic [31:0] d; logic e;
      rd(2, d, e);
      repeat (3) @(negedge clk);
      chk("R11 hold idle", bus_rdata, 32'h0000_5555);
      wr(3, 32'h0000_0005, e);
      chk("R11 hold over write", bus_rdata, 32'h0000_5555);
      rd(2, d, e); chk("R11 new read", d, 32'h0000_5550);
   endtask

   initial begin
      rst = 1'b1; src_in = '0; bus_req = 1'b0; bus_we = 1'b0; bus_idx = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_raw();
      t_irq_mask();
      t_fiq_mask();
      t_soft();
      t_ro_writes();
      t_wo_reads();
      t_undef();
      t_hold();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule